// File: doc/BRIEF.md
# Sector Sync Detector with Flywheel

This block sits on the byte stream that arrives from a disc signal processor. It watches for the twelve-byte sector sync pattern and establishes sector framing. Every byte is forwarded together with its position within the sector, so that a downstream writer can store the complete sector, sync field included, in buffer memory. A strobe marks the first byte of each sector.

Once framing exists, a flywheel counter predicts where the next sync must appear. If the pattern is missing at that point and the interpolator is enabled, the block inserts a sector start itself and marks that strobe as inserted. A real sync that turns up at an unexpected position re-aligns the framing and raises a slip flag on that strobe. Detector and interpolator have separate enable inputs, which are driven from control registers elsewhere. The forwarded stream lags the input by the length of the pattern window, because the block only recognises a sync after all twelve bytes have been seen.

Top module: `ssync_framer`

## Requirements
- R1: While reset is low and right after it, `out_valid`, `out_sof`, `out_inserted`, `out_slip` and `out_locked` are 0 and `out_index` is 0.
- R2: With `det_en` high, the byte sequence 0x00, ten times 0xFF, 0x00 is a sync. Its first byte is forwarded with `out_sof`=1, `out_inserted`=0 and `out_index`=0, and its twelve bytes carry indices 0 to 11.
- R3: Every accepted input byte is forwarded unchanged and in order, one `out_valid` per byte. The first output appears with the twelfth accepted byte, and each byte leaves on the edge that accepts the byte eleven places after it.
- R4: While locked, `out_index` rises by one per forwarded byte up to SECTOR_LEN-1.
- R5: When locked and the byte after index SECTOR_LEN-1 is not a sync, with `interp_en` high that byte gets `out_index`=0, `out_sof`=1 and `out_inserted`=1.
- R6: In the case of R5 with `interp_en` low, framing is lost: that byte has `out_locked`=0, `out_sof`=0 and `out_index`=0, and the index stays 0 until a new sync.
- R7: A sync detected while locked at any index other than the predicted one re-aligns framing to index 0, with `out_sof`=1, `out_inserted`=0 and `out_slip`=1.
- R8: A sync detected at the predicted position gives `out_sof`=1 with `out_slip`=0 and `out_inserted`=0.
- R9: With both `det_en` and `interp_en` low, no `out_sof` is produced, `out_locked` is 0 and `out_index` holds 0.
- R10: With `det_en` low, sync patterns in the stream are ignored: from an unlocked state, no strobe and no lock result.
- R11: A cycle without `in_valid` produces no `out_valid` and leaves `out_index` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous reset, active low |
| det_en | input | 1 | Enables pattern detection |
| interp_en | input | 1 | Enables flywheel sync insertion |
| in_valid | input | 1 | Input byte present this cycle |
| in_byte | input | 8 | Input byte |
| out_valid | output | 1 | Forwarded byte present |
| out_byte | output | 8 | Forwarded byte |
| out_index | output | $clog2(SECTOR_LEN) | Byte position within the sector |
| out_sof | output | 1 | First byte of a sector |
| out_inserted | output | 1 | With out_sof: boundary was inserted rather than detected |
| out_slip | output | 1 | With out_sof: detected sync was off the predicted position |
| out_locked | output | 1 | Sector framing is established |

## Verification
The bench builds the block with SECTOR_LEN set to 40 and the pattern length left at 12, which gives a sector of 28 payload bytes. With that setting, several consecutive sectors, an inserted boundary followed by an on-time sync, and a sync that arrives 13 bytes into a sector all fit in a few hundred cycles. This makes the wrap at SECTOR_LEN-1, the flywheel prediction and the slip re-alignment reachable with a direct check on each forwarded byte.

// File: rtl/ssync_pkg.sv
// Package: shared constants and helpers for the sector sync framer.
// Assumes the sync pattern is one 0x00 byte, a run of 0xFF bytes and a final 0x00 byte.
package ssync_pkg;

    localparam int BYTE_W = 8;

    // Expected value of the byte at position pos inside a pattern of length len.
    function automatic logic [BYTE_W-1:0] sync_byte(input int pos, input int len);
        if (pos == 0 || pos == len - 1) begin
            return 8'h00;
        end
        return 8'hFF;
    endfunction

endpackage

// File: rtl/ssync_window.sv
// Module: sliding window over the last SYNC_LEN input bytes.
// On every accepted byte it shifts and presents three look-ahead results for the window
// as it will be after the shift: the oldest byte (the one to forward), whether the
// window is full and whether it equals the sync pattern.
// Assumes SYNC_LEN >= 3.
module ssync_window
    import ssync_pkg::*;
#(
    parameter int SYNC_LEN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] oldest_nxt,
    output logic              full_nxt,
    output logic              match_nxt
);

    localparam int FILL_W = $clog2(SYNC_LEN + 1);

    logic [BYTE_W-1:0] win [SYNC_LEN];
    logic [BYTE_W-1:0] nxt [SYNC_LEN];
    logic [SYNC_LEN-1:0] hits;
    logic [FILL_W-1:0] fill;

    // Window contents after the pending shift, and the per-position pattern compare.
    generate
        for (genvar i = 0; i < SYNC_LEN; i++) begin : g_pos
            if (i == SYNC_LEN - 1) begin : g_new
                assign nxt[i] = din;
            end else begin : g_old
                assign nxt[i] = win[i+1];
            end
            assign hits[i] = (nxt[i] == sync_byte(i, SYNC_LEN));
        end
    endgenerate

    assign oldest_nxt = nxt[0];
    assign full_nxt   = (fill >= FILL_W'(SYNC_LEN - 1));
    assign match_nxt  = &hits;

    // Shift register holding the most recent bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_LEN; i++) begin
                win[i] <= '0;
            end
        end else if (shift) begin
            for (int i = 0; i < SYNC_LEN; i++) begin
                win[i] <= nxt[i];
            end
        end
    end

    // Counts the bytes received until the window is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill <= '0;
        end else if (shift && fill != FILL_W'(SYNC_LEN)) begin
            fill <= fill + 1'b1;
        end
    end

endmodule

// File: rtl/ssync_flywheel.sv
// Module: sector position counter with flywheel prediction.
// It advances once per forwarded byte. A detected sync restarts the sector, and a missing
// sync at the predicted place is either inserted or ends the lock. All outputs are
// registered and line up with the forwarded byte.
// Assumes hit is only raised together with step.
module ssync_flywheel #(
    parameter int SECTOR_LEN = 2352,
    localparam int IDX_W = $clog2(SECTOR_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             hit,
    input  logic             det_en,
    input  logic             interp_en,
    output logic [IDX_W-1:0] idx,
    output logic             sof,
    output logic             inserted,
    output logic             slip,
    output logic             locked
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SECTOR_LEN - 1);

    logic             due;
    logic             hit_q;
    logic [IDX_W-1:0] idx_d;
    logic             sof_d, ins_d, slip_d, lock_d;

    assign due   = locked && (idx == LAST_IDX);
    assign hit_q = hit && det_en;

    // Next framing state for the byte being forwarded.
    always_comb begin
        idx_d  = idx;
        sof_d  = 1'b0;
        ins_d  = 1'b0;
        slip_d = 1'b0;
        lock_d = locked;
        if (!det_en && !interp_en) begin
            idx_d  = '0;
            lock_d = 1'b0;
        end else if (step) begin
            if (hit_q) begin
                idx_d  = '0;
                sof_d  = 1'b1;
                slip_d = locked && !due;
                lock_d = 1'b1;
            end else if (due && interp_en) begin
                idx_d  = '0;
                sof_d  = 1'b1;
                ins_d  = 1'b1;
            end else if (due) begin
                idx_d  = '0;
                lock_d = 1'b0;
            end else if (locked) begin
                idx_d  = idx + 1'b1;
            end else begin
                idx_d  = '0;
            end
        end
    end

    // Registers holding the framing state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            sof      <= 1'b0;
            inserted <= 1'b0;
            slip     <= 1'b0;
            locked   <= 1'b0;
        end else begin
            idx      <= idx_d;
            sof      <= sof_d;
            inserted <= ins_d;
            slip     <= slip_d;
            locked   <= lock_d;
        end
    end

endmodule

// File: rtl/ssync_framer.sv
// Module: top of the sector sync framer.
// It passes the input bytes through the pattern window and forwards each byte, once the
// window holds it as its oldest entry, with its sector index and start strobe.
// Assumes one byte per cycle at most, marked by in_valid.
module ssync_framer
    import ssync_pkg::*;
#(
    parameter int SECTOR_LEN = 2352,
    parameter int SYNC_LEN   = 12,
    localparam int IDX_W = $clog2(SECTOR_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             det_en,
    input  logic             interp_en,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic [IDX_W-1:0] out_index,
    output logic             out_sof,
    output logic             out_inserted,
    output logic             out_slip,
    output logic             out_locked
);

    logic [BYTE_W-1:0] oldest_nxt;
    logic              full_nxt;
    logic              match_nxt;
    logic              step;

    assign step = in_valid && full_nxt;

    ssync_window #(.SYNC_LEN(SYNC_LEN)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift      (in_valid),
        .din        (in_byte),
        .oldest_nxt (oldest_nxt),
        .full_nxt   (full_nxt),
        .match_nxt  (match_nxt)
    );

    ssync_flywheel #(.SECTOR_LEN(SECTOR_LEN)) u_flywheel (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .hit       (step && match_nxt),
        .det_en    (det_en),
        .interp_en (interp_en),
        .idx       (out_index),
        .sof       (out_sof),
        .inserted  (out_inserted),
        .slip      (out_slip),
        .locked    (out_locked)
    );

    // Output data register, aligned with the flywheel outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else begin
            out_valid <= step;
            if (step) begin
                out_byte <= oldest_nxt;
            end
        end
    end

endmodule

// File: rtl/ssync_checker.sv
// Module: assertion checker for the sector sync framer, attached to the top by bind.
module ssync_checker #(
    parameter int SECTOR_LEN = 2352,
    localparam int IDX_W = $clog2(SECTOR_LEN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             det_en,
    input logic             interp_en,
    input logic             in_valid,
    input logic             out_valid,
    input logic [IDX_W-1:0] out_index,
    input logic             out_sof,
    input logic             out_inserted,
    input logic             out_slip,
    input logic             out_locked
);

    logic [IDX_W-1:0] prev_idx;
    logic             prev_locked;

    // Tracks the index and lock state of the previous forwarded byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_idx    <= '0;
            prev_locked <= 1'b0;
        end else if (out_valid) begin
            prev_idx    <= out_index;
            prev_locked <= out_locked;
        end
    end

    AST_SOF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_valid && out_index == '0 && out_locked)); // R2

    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_locked && !out_sof && prev_locked) |-> (out_index == prev_idx + 1'b1)); // R4

    AST_INDEX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_index <= IDX_W'(SECTOR_LEN - 1)); // R4

    AST_INSERT_NEEDS_INTERP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof && out_inserted) |-> $past(interp_en)); // R5

    AST_SLIP_IS_DETECTED: assert property (@(posedge clk) disable iff (!rst_n)
        out_slip |-> (out_sof && !out_inserted)); // R7

    AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!det_en && !interp_en) |-> (!out_sof && !out_locked && out_index == '0)); // R9

    AST_DETECT_NEEDS_DET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof && !out_inserted) |-> $past(det_en)); // R10

    AST_NO_VALID_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!in_valid) |-> !out_valid); // R11

    AST_HOLD_ON_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!in_valid && (det_en || interp_en)) |-> $stable(out_index)); // R11

endmodule

bind ssync_framer ssync_checker #(.SECTOR_LEN(SECTOR_LEN)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .det_en       (det_en),
    .interp_en    (interp_en),
    .in_valid     (in_valid),
    .out_valid    (out_valid),
    .out_index    (out_index),
    .out_sof      (out_sof),
    .out_inserted (out_inserted),
    .out_slip     (out_slip),
    .out_locked   (out_locked)
);

// File: tb/ssync_framer_tb.sv
`timescale 1ns/1ps
// Directed bench for the sector sync framer: one task for each scenario.
module ssync_framer_tb;

    localparam int SECTOR_LEN = 40;
    localparam int SYNC_LEN   = 12;
    localparam int IDX_W      = $clog2(SECTOR_LEN);
    localparam int PAD        = SYNC_LEN - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             det_en = 1'b0;
    logic             interp_en = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_byte = '0;
    logic             out_valid;
    logic [7:0]       out_byte;
    logic [IDX_W-1:0] out_index;
    logic             out_sof, out_inserted, out_slip, out_locked;

    int checks = 0;
    int errors = 0;

    logic [7:0] stim [512];
    int         n_stim;
    logic [7:0] r_byte [512];
    int         r_idx  [512];
    logic       r_sof  [512];
    logic       r_ins  [512];
    logic       r_slip [512];
    logic       r_lock [512];
    int         n_rec;

    ssync_framer #(.SECTOR_LEN(SECTOR_LEN), .SYNC_LEN(SYNC_LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .det_en(det_en), .interp_en(interp_en),
        .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_byte(out_byte), .out_index(out_index),
        .out_sof(out_sof), .out_inserted(out_inserted), .out_slip(out_slip),
        .out_locked(out_locked)
    );

    always #2.5 clk = ~clk;

    // Records every forwarded byte, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && out_valid && n_rec < 512) begin
            r_byte[n_rec] = out_byte;
            r_idx[n_rec]  = int'(out_index);
            r_sof[n_rec]  = out_sof;
            r_ins[n_rec]  = out_inserted;
            r_slip[n_rec] = out_slip;
            r_lock[n_rec] = out_locked;
            n_rec = n_rec + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_rec = 0;
        n_stim = 0;
    endtask

    task automatic add_sync();
        for (int i = 0; i < SYNC_LEN; i++) begin
            stim[n_stim] = (i == 0 || i == SYNC_LEN - 1) ? 8'h00 : 8'hFF;
            n_stim++;
        end
    endtask

    task automatic add_pay(input int n);
        for (int i = 0; i < n; i++) begin
            stim[n_stim] = 8'h20 + 8'((n_stim * 7) % 90);
            n_stim++;
        end
    endtask

    task automatic add_sector();
        add_sync();
        add_pay(SECTOR_LEN - SYNC_LEN);
    endtask

    task automatic play(input int from, input int to);
        for (int i = from; i < to; i++) begin
            in_valid = 1'b1;
            in_byte  = stim[i];
            @(negedge clk);
        end
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_sof && !out_locked && out_index == '0 && !out_inserted && !out_slip,
            "R1", "outputs in reset", int'(out_index), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !out_sof && !out_locked && out_index == '0,
            "R1", "outputs after reset", int'(out_valid), 0);
    endtask

    task automatic t_detect();
        bit bytes_ok = 1'b1;
        do_reset();
        det_en = 1'b1; interp_en = 1'b1;
        add_pay(5); add_sector(); add_sector(); add_pay(PAD);
        play(0, n_stim);
        chk(n_rec == n_stim - PAD, "R3", "forwarded count", n_rec, n_stim - PAD);
        for (int j = 0; j < n_rec; j++) begin
            if (r_byte[j] !== stim[j]) bytes_ok = 1'b0;
        end
        chk(bytes_ok, "R3", "bytes in order", 0, 0);
        chk(r_lock[4] == 1'b0 && r_idx[4] == 0, "R2", "unlocked before sync", r_idx[4], 0);
        chk(r_sof[5] && !r_ins[5] && r_idx[5] == 0 && r_byte[5] == 8'h00, "R2", "sync strobe",
            int'(r_sof[5]), 1);
        chk(r_idx[16] == 11, "R2", "last sync byte index", r_idx[16], 11);
        chk(r_idx[44] == SECTOR_LEN - 1, "R4", "last index of sector", r_idx[44], SECTOR_LEN - 1);
        chk(r_sof[45] && !r_slip[45] && !r_ins[45] && r_idx[45] == 0, "R8", "on-time sync",
            int'(r_slip[45]), 0);
    endtask

    task automatic t_flywheel();
        do_reset();
        det_en = 1'b1; interp_en = 1'b1;
        add_sector(); add_pay(SECTOR_LEN); add_sector(); add_pay(PAD);
        play(0, n_stim);
        chk(r_sof[40] && r_ins[40] && r_idx[40] == 0 && r_lock[40], "R5", "inserted strobe",
            int'(r_ins[40]), 1);
        chk(r_idx[41] == 1, "R5", "index after insert", r_idx[41], 1);
        chk(r_sof[80] && !r_ins[80] && !r_slip[80], "R8", "sync after insert", int'(r_slip[80]), 0);
    endtask

    task automatic t_no_interp();
        do_reset();
        det_en = 1'b1; interp_en = 1'b0;
        add_sector(); add_pay(SECTOR_LEN); add_pay(PAD);
        play(0, n_stim);
        chk(r_idx[39] == SECTOR_LEN - 1 && r_lock[39], "R4", "index before missing sync",
            r_idx[39], SECTOR_LEN - 1);
        chk(!r_sof[40] && !r_lock[40] && r_idx[40] == 0, "R6", "lock lost", int'(r_lock[40]), 0);
        chk(r_idx[60] == 0 && !r_lock[60], "R6", "index stays zero", r_idx[60], 0);
    endtask

    task automatic t_slip();
        do_reset();
        det_en = 1'b1; interp_en = 1'b1;
        add_sector(); add_pay(13); add_sector(); add_pay(PAD);
        play(0, n_stim);
        chk(r_sof[40] && r_ins[40], "R5", "insert before slip", int'(r_ins[40]), 1);
        chk(r_idx[52] == 12, "R4", "index before early sync", r_idx[52], 12);
        chk(r_sof[53] && r_slip[53] && !r_ins[53] && r_idx[53] == 0, "R7", "slip strobe",
            int'(r_slip[53]), 1);
        chk(r_idx[54] == 1, "R7", "index after re-align", r_idx[54], 1);
    endtask

    task automatic t_disabled(input logic det, input logic interp, input string req);
        int bad = 0;
        do_reset();
        det_en = det; interp_en = interp;
        add_pay(3); add_sector(); add_sector(); add_pay(PAD);
        play(0, n_stim);
        for (int j = 0; j < n_rec; j++) begin
            if (r_sof[j] || r_lock[j] || r_idx[j] != 0) bad++;
        end
        chk(bad == 0 && n_rec > 0, req, "no framing produced", bad, 0);
    endtask

    task automatic t_stall();
        logic [IDX_W-1:0] held;
        do_reset();
        det_en = 1'b1; interp_en = 1'b1;
        add_pay(2); add_sector(); add_pay(PAD);
        for (int i = 0; i < 22; i++) begin
            in_valid = 1'b1;
            in_byte  = stim[i];
            @(negedge clk);
        end
        in_valid = 1'b0;
        held = out_index;
        chk(held == 8, "R4", "index before gap", int'(held), 8);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!out_valid && out_index == held, "R11", "gap hold", int'(out_index), int'(held));
        end
        play(22, n_stim);
        chk(r_idx[11] == 9 && r_sof[2], "R11", "index resumes", r_idx[11], 9);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_detect();
        t_flywheel();
        t_no_interp();
        t_slip();
        t_disabled(1'b0, 1'b0, "R9");
        t_disabled(1'b0, 1'b1, "R10");
        t_stall();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule